// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steps a 64-bit processor into and out of interrupt handlers. At an instruction boundary it takes one request: an exception, a hardware interrupt, a software interrupt or a handler return. Each request carries a vector index and a 64-bit auxiliary value.

For an entry, the block reads one 8-byte descriptor from a 512-entry vector table through a 64-bit memory port. It pushes a six-word context frame onto an upward-growing stack. It then hands new IP, FP, SP, R0 and R1 values to the register file, together with a write-enable mask.

For a return, it rebuilds the stack pointer from the frame pointer and pops the frame back in reverse order. All memory accesses wait on a ready handshake. The register file samples the results on a one-cycle done pulse.

Top module: `intr_seq`

## Requirements
- R1: An entry reads exactly one descriptor word, at address `vtb_i + index*8`. The vector table base must be a multiple of 64.
- R2: A descriptor is rejected under any of three conditions: bit 63 (enable) is clear, bits 62..59 (reserved) are not all zero, or bit 58 is set (the scaled address would not fit in 64 bits). A rejected descriptor produces no stack write and a done pulse with `err_o` high. `ctx_we_o` is zero in that pulse.
- R3: An accepted entry writes six words at SP, SP+8, ... SP+40, in this order: FP, IP of next instruction, FLAGS, STATUS, R0, R1. No other memory access is made.
- R4: On a successful entry, the done pulse carries `ctx_we_o` = 7'h67 (bit 0 IP, bit 1 FP, bit 2 SP, bit 5 R0, bit 6 R1). The values are: IP = descriptor bits 57..0 times 64, FP = the old SP, SP = old SP+48, R0 = the vector taken, R1 = the auxiliary value.
- R5: A return sets SP to FP+48 and reads the words at FP+40 down to FP. These restore R1, R0, STATUS, FLAGS, IP and FP in that order. The final SP equals the old FP, and `ctx_we_o` = 7'h7f (bit 3 FLAGS, bit 4 STATUS).
- R6: Simultaneous requests are served in this order: exception, hardware, software, return. `grant_o` (bit 0 exception, 1 hardware, 2 software, 3 return) has at most one bit set.
- R7: While `mask_i` is high, no exception, hardware or software request is granted and no memory access starts. Returns are still granted.
- R8: `ready_o` is high only while idle, and nothing is granted while `ready_o` is low.
- R9: An exception with index 0, 1 or 2 that arrives while at least one handler is active is taken as vector `DF_VEC` (default 4). Its auxiliary value is kept.
- R10: While `mem_ready_i` is low, a pending memory request keeps its address, direction and write data unchanged.
- R11: After reset the block is idle: `ready_o` is 1, and `mem_req_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_i | input | 1 | Blocks interrupt and exception requests |
| exc_req_i | input | 1 | Exception request |
| exc_idx_i | input | 8 | Exception vector (0..255) |
| exc_aux_i | input | 64 | Exception auxiliary value |
| hw_req_i | input | 1 | Hardware interrupt request |
| hw_idx_i | input | 9 | Hardware vector index |
| hw_aux_i | input | 64 | Hardware auxiliary value |
| sw_req_i | input | 1 | Software interrupt request |
| sw_idx_i | input | 9 | Software vector index |
| sw_aux_i | input | 64 | Software auxiliary value |
| ret_req_i | input | 1 | Handler return request |
| grant_o | output | 4 | One-hot acceptance of a request this cycle |
| ready_o | output | 1 | Idle, can accept a request |
| vtb_i | input | 64 | Vector table base |
| ip_i | input | 64 | IP of next instruction |
| fp_i | input | 64 | Current frame pointer |
| sp_i | input | 64 | Current stack pointer |
| flags_i | input | 64 | Current FLAGS |
| status_i | input | 64 | Current STATUS |
| r0_i | input | 64 | Current R0 |
| r1_i | input | 64 | Current R1 |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was a rejected entry |
| ctx_we_o | output | 7 | Register write mask for the done pulse |
| ip_o | output | 64 | New IP |
| fp_o | output | 64 | New FP |
| sp_o | output | 64 | New SP |
| flags_o | output | 64 | Restored FLAGS |
| status_o | output | 64 | Restored STATUS |
| r0_o | output | 64 | New R0 |
| r1_o | output | 64 | New R1 |

## Verification
The bench builds the block with its defaults: 512 vectors, 256 exception vectors, a 4-bit nesting counter and DF_VEC = 4. These values let the tests reach the last table entry (index 511, address base+4088), a software vector well above the exception range, and a double fault at nesting depth one. The memory model inserts wait states every few cycles, so every read and write is held across stalls. Nested entries are unwound by consecutive returns.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int XLEN        = 64;
  localparam int WORD_BYTES  = 8;
  localparam int FRAME_WORDS = 6;
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
  localparam int SLOT_W      = 3;
  localparam int NUM_SRC     = 4;
  localparam int CTX_REGS    = 7;

  // grant bit positions, also the priority order (lowest bit wins)
  localparam int GR_EXC = 0;
  localparam int GR_HW  = 1;
  localparam int GR_SW  = 2;
  localparam int GR_RET = 3;

  // register-file write mask positions
  localparam int WE_IP = 0;
  localparam int WE_FP = 1;
  localparam int WE_SP = 2;
  localparam int WE_FL = 3;
  localparam int WE_ST = 4;
  localparam int WE_R0 = 5;
  localparam int WE_R1 = 6;

  localparam logic [CTX_REGS-1:0] ENTRY_WE = CTX_REGS'(7'h67);
  localparam logic [CTX_REGS-1:0] RETURN_WE = CTX_REGS'(7'h7f);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PUSH,
    ST_POP
  } seq_state_t;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_i,
  input  logic               mask_i,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o
);
  logic [NUM_SRC-1:0] eligible;

  always_comb begin
    eligible = req_i;
    if (mask_i) begin
      eligible[GR_EXC] = 1'b0;
      eligible[GR_HW]  = 1'b0;
      eligible[GR_SW]  = 1'b0;
    end
    if (!idle_i) eligible = '0;
  end

  // lowest index wins
  always_comb begin
    grant_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) grant_o = NUM_SRC'(1) << i;
    end
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  assert_grant_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_o[GR_HW] || grant_o[GR_SW] || grant_o[GR_RET]) |-> !req_i[GR_EXC] || mask_i);
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    mask_i |-> !(grant_o[GR_EXC] || grant_o[GR_HW] || grant_o[GR_SW]));
  assert_no_grant_busy_R8: assert property (@(posedge clk) disable iff (rst)
    !idle_i |-> grant_o == '0);
endmodule

// File: rtl/intr_vec_decode.sv
module intr_vec_decode
  import intr_pkg::*;
#(
  parameter int IDX_W    = 9,
  parameter int ALIGN_SH = 6
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  word_i,
  output logic [XLEN-1:0]  ent_addr_o,
  output logic             ent_ok_o,
  output logic [XLEN-1:0]  handler_o
);
  localparam int OFS_SH  = $clog2(WORD_BYTES);
  localparam int FIELD_W = XLEN - 5;
  localparam int KEEP_W  = XLEN - ALIGN_SH;

  logic             en_bit;
  logic [3:0]       rsv_bits;
  logic [FIELD_W-1:0] field;

  assign ent_addr_o = base_i + (XLEN'(idx_i) << OFS_SH);
  assign en_bit     = word_i[XLEN-1];
  assign rsv_bits   = word_i[XLEN-2 -: 4];
  assign field      = word_i[FIELD_W-1:0];

  // field bits above KEEP_W would leave the address space after scaling
  assign ent_ok_o  = en_bit && (rsv_bits == 4'b0) &&
                     (field[FIELD_W-1:KEEP_W] == '0);
  assign handler_o = {field[KEEP_W-1:0], {ALIGN_SH{1'b0}}};
endmodule

// File: rtl/intr_frame_mux.sv
module intr_frame_mux
  import intr_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [XLEN-1:0]   fp_i,
  input  logic [XLEN-1:0]   ip_i,
  input  logic [XLEN-1:0]   flags_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   r0_i,
  input  logic [XLEN-1:0]   r1_i,
  output logic [XLEN-1:0]   word_o
);
  always_comb begin
    unique case (slot_i)
      3'd0:    word_o = fp_i;
      3'd1:    word_o = ip_i;
      3'd2:    word_o = flags_i;
      3'd3:    word_o = status_i;
      3'd4:    word_o = r0_i;
      default: word_o = r1_i;
    endcase
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_pkg::*;
#(
  parameter int VEC_COUNT = 512,
  parameter int EXC_COUNT = 256,
  parameter int DEPTH_W   = 4,
  parameter int DF_VEC    = 4,
  parameter int ALIGN_SH  = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mask_i,
  input  logic                         exc_req_i,
  input  logic [$clog2(EXC_COUNT)-1:0] exc_idx_i,
  input  logic [63:0]                  exc_aux_i,
  input  logic                         hw_req_i,
  input  logic [$clog2(VEC_COUNT)-1:0] hw_idx_i,
  input  logic [63:0]                  hw_aux_i,
  input  logic                         sw_req_i,
  input  logic [$clog2(VEC_COUNT)-1:0] sw_idx_i,
  input  logic [63:0]                  sw_aux_i,
  input  logic                         ret_req_i,
  output logic [3:0]                   grant_o,
  output logic                         ready_o,
  input  logic [63:0]                  vtb_i,
  input  logic [63:0]                  ip_i,
  input  logic [63:0]                  fp_i,
  input  logic [63:0]                  sp_i,
  input  logic [63:0]                  flags_i,
  input  logic [63:0]                  status_i,
  input  logic [63:0]                  r0_i,
  input  logic [63:0]                  r1_i,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [63:0]                  mem_addr_o,
  output logic [63:0]                  mem_wdata_o,
  input  logic [63:0]                  mem_rdata_i,
  input  logic                         mem_ready_i,
  output logic                         done_o,
  output logic                         err_o,
  output logic [6:0]                   ctx_we_o,
  output logic [63:0]                  ip_o,
  output logic [63:0]                  fp_o,
  output logic [63:0]                  sp_o,
  output logic [63:0]                  flags_o,
  output logic [63:0]                  status_o,
  output logic [63:0]                  r0_o,
  output logic [63:0]                  r1_o
);
  localparam int IDX_W = $clog2(VEC_COUNT);
  localparam int EXC_W = $clog2(EXC_COUNT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_WORDS - 1);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] FRAME_SPAN = XLEN'(FRAME_BYTES);
  localparam int ILLEGAL_LAST = 2;

  seq_state_t         st;
  logic [SLOT_W-1:0]  slot;
  logic [DEPTH_W-1:0] depth;
  logic [IDX_W-1:0]   idx_q;
  logic [XLEN-1:0]    aux_q, vtb_q, sp_w, hnd_q;
  logic [XLEN-1:0]    fp_s, ip_s, fl_s, st_s, r0_s, r1_s;
  logic [XLEN-1:0]    ent_addr, ent_hnd, push_word;
  logic               ent_ok, dfault, idle;
  logic [NUM_SRC-1:0] reqs;

  assign idle    = (st == ST_IDLE);
  assign ready_o = idle;
  assign reqs    = {ret_req_i, sw_req_i, hw_req_i, exc_req_i};
  assign dfault  = (depth != '0) && (exc_idx_i <= EXC_W'(ILLEGAL_LAST));

  intr_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .idle_i  (idle),
    .mask_i  (mask_i),
    .req_i   (reqs),
    .grant_o (grant_o)
  );

  intr_vec_decode #(.IDX_W(IDX_W), .ALIGN_SH(ALIGN_SH)) u_dec (
    .base_i     (vtb_q),
    .idx_i      (idx_q),
    .word_i     (mem_rdata_i),
    .ent_addr_o (ent_addr),
    .ent_ok_o   (ent_ok),
    .handler_o  (ent_hnd)
  );

  intr_frame_mux u_mux (
    .slot_i   (slot),
    .fp_i     (fp_s),
    .ip_i     (ip_s),
    .flags_i  (fl_s),
    .status_i (st_s),
    .r0_i     (r0_s),
    .r1_i     (r1_s),
    .word_o   (push_word)
  );

  always_comb begin
    mem_req_o   = (st != ST_IDLE);
    mem_we_o    = (st == ST_PUSH);
    mem_wdata_o = push_word;
    unique case (st)
      ST_FETCH: mem_addr_o = ent_addr;
      ST_PUSH:  mem_addr_o = sp_w;
      default:  mem_addr_o = sp_w - STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      slot     <= '0;
      depth    <= '0;
      idx_q    <= '0;
      aux_q    <= '0;
      vtb_q    <= '0;
      sp_w     <= '0;
      hnd_q    <= '0;
      fp_s     <= '0;
      ip_s     <= '0;
      fl_s     <= '0;
      st_s     <= '0;
      r0_s     <= '0;
      r1_s     <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      ctx_we_o <= '0;
      ip_o     <= '0;
      fp_o     <= '0;
      sp_o     <= '0;
      flags_o  <= '0;
      status_o <= '0;
      r0_o     <= '0;
      r1_o     <= '0;
    end else begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      ctx_we_o <= '0;
      unique case (st)
        ST_IDLE: begin
          if (grant_o != '0) begin
            slot <= '0;
            fp_s <= fp_i;
            ip_s <= ip_i;
            fl_s <= flags_i;
            st_s <= status_i;
            r0_s <= r0_i;
            r1_s <= r1_i;
            if (grant_o[GR_RET]) begin
              sp_w <= fp_i + FRAME_SPAN;
              st   <= ST_POP;
            end else begin
              sp_w  <= sp_i;
              vtb_q <= vtb_i;
              st    <= ST_FETCH;
              if (grant_o[GR_EXC]) begin
                idx_q <= dfault ? IDX_W'(DF_VEC) : IDX_W'(exc_idx_i);
                aux_q <= exc_aux_i;
              end else if (grant_o[GR_HW]) begin
                idx_q <= hw_idx_i;
                aux_q <= hw_aux_i;
              end else begin
                idx_q <= sw_idx_i;
                aux_q <= sw_aux_i;
              end
            end
          end
        end
        ST_FETCH: begin
          if (mem_ready_i) begin
            if (!ent_ok) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              hnd_q <= ent_hnd;
              st    <= ST_PUSH;
            end
          end
        end
        ST_PUSH: begin
          if (mem_ready_i) begin
            sp_w <= sp_w + STEP;
            slot <= slot + 1'b1;
            if (slot == LAST_SLOT) begin
              done_o   <= 1'b1;
              ctx_we_o <= ENTRY_WE;
              ip_o     <= hnd_q;
              sp_o     <= sp_w + STEP;
              fp_o     <= sp_w + STEP - FRAME_SPAN;
              r0_o     <= XLEN'(idx_q);
              r1_o     <= aux_q;
              if (depth != DEPTH_MAX) depth <= depth + 1'b1;
              st <= ST_IDLE;
            end
          end
        end
        ST_POP: begin
          if (mem_ready_i) begin
            sp_w <= sp_w - STEP;
            slot <= slot + 1'b1;
            unique case (slot)
              3'd0: r1_o     <= mem_rdata_i;
              3'd1: r0_o     <= mem_rdata_i;
              3'd2: status_o <= mem_rdata_i;
              3'd3: flags_o  <= mem_rdata_i;
              3'd4: ip_o     <= mem_rdata_i;
              default: begin
                fp_o     <= mem_rdata_i;
                sp_o     <= sp_w - STEP;
                done_o   <= 1'b1;
                ctx_we_o <= RETURN_WE;
                if (depth != '0) depth <= depth - 1'b1;
                st <= ST_IDLE;
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_err_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> ctx_we_o == '0);
  assert_push_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o && mem_ready_i && slot != LAST_SLOT) |=>
      (mem_we_o && mem_addr_o == $past(mem_addr_o) + STEP));
  assert_entry_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && ctx_we_o == ENTRY_WE) |-> sp_o == fp_o + FRAME_SPAN);
  assert_return_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && ctx_we_o != ENTRY_WE) |-> ctx_we_o == RETURN_WE);
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !mem_req_o);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/intr_seq_tb.sv
module intr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic        we;
    logic [63:0] addr;
    logic [63:0] data;
    int          tag;
  } acc_t;

  typedef struct {
    logic [63:0] w [6];
  } frame_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mask = 1'b0;
  logic exc_req = 1'b0, hw_req = 1'b0, sw_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  exc_idx = '0;
  logic [8:0]  hw_idx = '0, sw_idx = '0;
  logic [63:0] exc_aux = '0, hw_aux = '0, sw_aux = '0;
  logic [63:0] m_vtb = 64'h10000, m_ip = 64'h400, m_fp = 64'h1ff80, m_sp = 64'h20000;
  logic [63:0] m_fl = 64'h5, m_st = 64'h77, m_r0 = 64'h11, m_r1 = 64'h22;
  logic [3:0]  grant;
  logic        ready, mem_req, mem_we, done, err;
  logic [63:0] mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ready = 1'b1;
  logic [6:0]  ctx_we;
  logic [63:0] ip_o, fp_o, sp_o, fl_o, st_o, r0_o, r1_o;

  logic [63:0] mem [logic [63:0]];
  acc_t        exp_q [$];
  frame_t      frames [$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic        stall = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intr_seq dut_i (
    .clk(clk), .rst(rst), .mask_i(mask),
    .exc_req_i(exc_req), .exc_idx_i(exc_idx), .exc_aux_i(exc_aux),
    .hw_req_i(hw_req), .hw_idx_i(hw_idx), .hw_aux_i(hw_aux),
    .sw_req_i(sw_req), .sw_idx_i(sw_idx), .sw_aux_i(sw_aux),
    .ret_req_i(ret_req), .grant_o(grant), .ready_o(ready),
    .vtb_i(m_vtb), .ip_i(m_ip), .fp_i(m_fp), .sp_i(m_sp),
    .flags_i(m_fl), .status_i(m_st), .r0_i(m_r0), .r1_i(m_r1),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .done_o(done), .err_o(err), .ctx_we_o(ctx_we),
    .ip_o(ip_o), .fp_o(fp_o), .sp_o(sp_o), .flags_o(fl_o),
    .status_o(st_o), .r0_o(r0_o), .r1_o(r1_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor: all work at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
    if (!rst && mem_req && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected access", mem_addr, 64'h0);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr,
            $sformatf("R%0d access address", e.tag), mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.data, "R3 pushed word", mem_wdata, e.data);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic set_reqs(input logic [3:0] r, input logic [8:0] idx, input logic [63:0] aux);
    exc_req = r[0]; hw_req = r[1]; sw_req = r[2]; ret_req = r[3];
    exc_idx = idx[7:0]; hw_idx = idx; sw_idx = idx;
    exc_aux = aux; hw_aux = aux; sw_aux = aux;
  endtask

  task automatic take_grant(input logic [3:0] exp_g);
    int n = 0;
    #1;
    while (grant == 4'b0 && n < 50) begin
      @(negedge clk); #1; n++;
    end
    chk(grant == exp_g, "R6 granted source", 64'(grant), 64'(exp_g));
    @(negedge clk);
    set_reqs(4'b0, 9'h0, 64'h0);
    mask = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    logic busy_ok = 1'b1;
    while (!done && n < 300) begin
      if (ready) busy_ok = 1'b0;
      @(negedge clk); n++;
    end
    chk(busy_ok, "R8 ready low while busy", 64'(busy_ok), 64'h1);
    chk(done, "R11 done pulse seen", 64'(done), 64'h1);
    if (ctx_we[0]) m_ip = ip_o;
    if (ctx_we[1]) m_fp = fp_o;
    if (ctx_we[2]) m_sp = sp_o;
    if (ctx_we[3]) m_fl = fl_o;
    if (ctx_we[4]) m_st = st_o;
    if (ctx_we[5]) m_r0 = r0_o;
    if (ctx_we[6]) m_r1 = r1_o;
  endtask

  task automatic run_entry(input logic [3:0] r, input logic [3:0] exp_g,
                           input logic [8:0] idx_in, input logic [8:0] taken,
                           input logic [63:0] aux, input logic en,
                           input logic [58:0] field, input logic hold_mask);
    logic [63:0] ent, sp_b;
    logic ok;
    frame_t f;
    ok   = en && !field[58];
    sp_b = m_sp;
    ent  = m_vtb + 64'(taken) * 8;
    mem[ent] = {en, 4'b0, field};
    exp_q.push_back('{1'b0, ent, 64'h0, 1});
    if (ok) begin
      f.w[0] = m_fp; f.w[1] = m_ip; f.w[2] = m_fl;
      f.w[3] = m_st; f.w[4] = m_r0; f.w[5] = m_r1;
      for (int k = 0; k < 6; k++) exp_q.push_back('{1'b1, sp_b + 64'(8 * k), f.w[k], 3});
      frames.push_back(f);
    end
    @(negedge clk);
    set_reqs(r, idx_in, aux);
    if (hold_mask) begin
      logic quiet = 1'b1;
      mask = 1'b1;
      for (int k = 0; k < 4; k++) begin
        #1;
        if (grant != 4'b0 || mem_req) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R7 masked requests not taken", 64'(quiet), 64'h1);
      mask = 1'b0;
    end
    take_grant(exp_g);
    wait_done();
    chk(err == !ok, "R2 error flag", 64'(err), 64'(!ok));
    if (ok) begin
      chk(ctx_we == 7'h67, "R4 entry write mask", 64'(ctx_we), 64'h67);
      chk(ip_o == {field[57:0], 6'b0}, "R4 handler IP", ip_o, {field[57:0], 6'b0});
      chk(fp_o == sp_b, "R4 new FP", fp_o, sp_b);
      chk(sp_o == sp_b + 48, "R4 new SP", sp_o, sp_b + 48);
      chk(r0_o == 64'(taken), "R9 R0 holds vector taken", r0_o, 64'(taken));
      chk(r1_o == aux, "R4 R1 auxiliary", r1_o, aux);
    end else begin
      chk(ctx_we == 7'h0, "R2 no register write", 64'(ctx_we), 64'h0);
    end
  endtask

  task automatic run_ret(input logic [3:0] r, input logic [3:0] exp_g, input logic with_mask);
    frame_t f;
    logic [63:0] fp_b;
    f = frames.pop_back();
    fp_b = m_fp;
    for (int k = 0; k < 6; k++)
      exp_q.push_back('{1'b0, fp_b + 64'(40 - 8 * k), 64'h0, 5});
    @(negedge clk);
    mask = with_mask;
    set_reqs(r, 9'd21, 64'h3);
    take_grant(exp_g);
    wait_done();
    chk(ctx_we == 7'h7f, "R5 return write mask", 64'(ctx_we), 64'h7f);
    chk(r1_o == f.w[5], "R5 R1 restored", r1_o, f.w[5]);
    chk(r0_o == f.w[4], "R5 R0 restored", r0_o, f.w[4]);
    chk(st_o == f.w[3], "R5 STATUS restored", st_o, f.w[3]);
    chk(fl_o == f.w[2], "R5 FLAGS restored", fl_o, f.w[2]);
    chk(ip_o == f.w[1], "R5 IP restored", ip_o, f.w[1]);
    chk(fp_o == f.w[0], "R5 FP restored", fp_o, f.w[0]);
    chk(sp_o == fp_b, "R5 SP back to old FP", sp_o, fp_b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(ready == 1'b1, "R11 ready after reset", 64'(ready), 64'h1);
    chk(mem_req == 1'b0, "R11 no request after reset", 64'(mem_req), 64'h0);
    chk(done == 1'b0, "R11 no done after reset", 64'(done), 64'h0);

    // R1 R3 R4: software entry, then return R5
    run_entry(4'b0100, 4'b0100, 9'd300, 9'd300, 64'hA5A5, 1'b1, 59'h123, 1'b0);
    run_ret(4'b1000, 4'b1000, 1'b0);

    // R10: wait states; last table entry; nested double fault R9
    stall = 1'b1;
    run_entry(4'b0010, 4'b0010, 9'd511, 9'd511, 64'hFEED, 1'b1, 59'h3_0000_0001, 1'b0);
    run_entry(4'b0001, 4'b0001, 9'd2, 9'd4, 64'hDEAD, 1'b1, 59'h40, 1'b0);
    run_ret(4'b1000, 4'b1000, 1'b0);
    run_ret(4'b1000, 4'b1000, 1'b0);
    stall = 1'b0;

    // R2: enable clear, then an address field out of range
    run_entry(4'b0100, 4'b0100, 9'd7, 9'd7, 64'h1, 1'b0, 59'h99, 1'b0);
    run_entry(4'b0100, 4'b0100, 9'd9, 9'd9, 64'h2, 1'b1, 59'h400_0000_0000_0001, 1'b0);

    // R6 R7: all three held under mask, exception wins at depth zero
    run_entry(4'b0111, 4'b0001, 9'd1, 9'd1, 64'hBEEF, 1'b1, 59'h200, 1'b1);
    run_ret(4'b1000, 4'b1000, 1'b0);
    run_entry(4'b0110, 4'b0010, 9'd20, 9'd20, 64'hC0DE, 1'b1, 59'h280, 1'b0);
    run_ret(4'b1000, 4'b1000, 1'b1);  // R7: return under mask
    run_entry(4'b1100, 4'b0100, 9'd21, 9'd21, 64'h3, 1'b1, 59'h300, 1'b0);
    run_ret(4'b1000, 4'b1000, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected accesses seen", 64'(exp_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule